// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into an asynchronous serial bit stream. A byte is written into a one-entry holding register with a single-cycle strobe. As soon as the shift stage is free it takes that byte, builds a complete frame and clocks it out on the serial line. The frame starts with a low start bit and carries 5 to 8 data bits, least significant bit first. An optional parity bit follows, which can be odd, even or fixed, and then one or two high stop bits. Between frames the line rests high.

The bit rate comes from a divisor. A counter running on the reference clock produces one oversampling tick every `divisor` cycles, and sixteen ticks make one bit time. A divisor of zero stops the ticks and freezes the frame in progress. The line format is sampled when a frame begins, so it can be changed for the next byte while the current one is still being sent. One control bit forces the line low for as long as it stays set. Two flags help software or a feeding FIFO pace its writes. One says the holding register can take a byte. The other says nothing is held and nothing is being shifted.

Top module: `sertx_top`

## Requirements
- R1: After reset `tx_out` is 1, `hold_empty` is 1 and `all_empty` is 1.
- R2: `line_ctl[1:0]` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the chosen length are not sent.
- R3: `line_ctl[2]` = 1 ends the frame with two stop bits at level 1. When it is 0 there is one.
- R4: `line_ctl[3]` = 1 inserts a parity bit right after the last data bit. With `line_ctl[5]` = 0, `line_ctl[4]` = 1 makes the count of ones over data and parity even, and `line_ctl[4]` = 0 makes it odd. With `line_ctl[5]` = 1 the parity bit is the inverse of `line_ctl[4]`.
- R5: A frame is one 0 start bit, then the data bits least significant first, then the optional parity bit, then the stop bits. The line is 1 whenever no frame is being sent.
- R6: Each bit lasts 16 x `divisor` clock cycles. Only the start bit may be shorter, by at most `divisor`-1 cycles. While `divisor` is 0 the frame in progress does not advance.
- R7: While `line_ctl[6]` is 1, `tx_out` is 0 from the next cycle on. Break does not change the flags or the frame timing.
- R8: A write strobe clears `hold_empty` on the next cycle. `hold_empty` goes back to 1 once the byte has moved into the shift stage, even while that frame is still being sent.
- R9: `all_empty` is 1 only when the holding register is empty and no frame is in progress. It returns to 1 after the last stop bit.
- R10: A write while the holding register is full replaces the held byte. Only the newest byte is sent.
- R11: The line format is captured when a frame starts. Changing `line_ctl[5:0]` during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe that writes `wr_data` into the holding register |
| wr_data | input | 8 | Byte to transmit |
| line_ctl | input | 7 | Line format: [1:0] data length, [2] two stop bits, [3] parity on, [4] even select, [5] fixed parity, [6] break |
| divisor | input | 16 | Reference cycles per oversampling tick; 0 stops the bit clock |
| tx_out | output | 1 | Serial output, registered |
| hold_empty | output | 1 | Holding register can take a byte |
| all_empty | output | 1 | Holding register empty and shift stage idle |

## Verification
The properties treat `line_ctl`, `divisor` and `wr_stb` as synchronous inputs that change only between rising edges. They assume nothing about how the divisor relates to frame boundaries, because the tick counter clamps itself when the divisor shrinks. The stimulus drives every input on the falling edge. It uses divisors of 1 to 5, with one stretch at zero. Writes go in only when `all_empty` shows the block is idle, except in the one directed case that deliberately overwrites a full holding register. The line format is changed at random in the middle of frames to exercise format capture.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 1 + DATA_W + 1 + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int OS_RATE = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    // Field order matches line_ctl bit positions, MSB first.
    typedef struct packed {
        logic       brk;
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_cfg_t;

endpackage

// File: rtl/sertx_tick_gen.sv
module sertx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             os_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic        at_limit;

    always_comb begin
        st_d     = st_q;
        at_limit = (divisor != '0) && (st_q.cnt >= divisor - DIV_W'(1));
        if (divisor == '0) begin
            st_d.cnt = '0;
        end else if (at_limit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    assign os_tick = at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sertx_frame_fmt.sv
module sertx_frame_fmt
    import sertx_pkg::*;
(
    input  logic [DATA_W-1:0]  data,
    input  logic [1:0]         wlen,
    input  logic               two_stop,
    input  logic               par_en,
    input  logic               par_even,
    input  logic               par_stick,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);

    int   nwl;
    logic ones_xor;
    logic par_bit;

    always_comb begin
        nwl      = 5 + int'(wlen);
        frame    = '1;
        frame[0] = 1'b0;
        ones_xor = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nwl) begin
                frame[1 + i] = data[i];
                ones_xor     = ones_xor ^ data[i];
            end
        end
        if (par_stick) begin
            par_bit = ~par_even;
        end else if (par_even) begin
            par_bit = ones_xor;
        end else begin
            par_bit = ~ones_xor;
        end
        if (par_en) begin
            frame[1 + nwl] = par_bit;
        end
        nbits = CNT_W'(2 + nwl + int'(par_en) + int'(two_stop));
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               os_tick,
    input  logic               wr_stb,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               brk,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    output logic [DATA_W-1:0]  hold_data,
    output logic               tx_out,
    output logic               hold_empty,
    output logic               all_empty
);

    localparam int              SUB_W   = $clog2(OS_RATE);
    localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(OS_RATE - 1);

    typedef struct packed {
        tx_state_e          st;
        logic               hold_full;
        logic [DATA_W-1:0]  hold;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   left;
        logic [SUB_W-1:0]   sub;
        logic               tx;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         take;

    always_comb begin
        st_d = st_q;
        take = (st_q.st == ST_IDLE) && st_q.hold_full;

        if (take) begin
            st_d.st        = ST_SEND;
            st_d.sh        = frame;
            st_d.left      = nbits;
            st_d.sub       = '0;
            st_d.hold_full = 1'b0;
        end else if (st_q.st == ST_SEND && os_tick) begin
            if (st_q.sub == SUB_MAX) begin
                st_d.sub  = '0;
                st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                st_d.left = st_q.left - CNT_W'(1);
                if (st_q.left == CNT_W'(1)) begin
                    st_d.st = ST_IDLE;
                end
            end else begin
                st_d.sub = st_q.sub + SUB_W'(1);
            end
        end

        // A write in the same cycle as a take refills the register.
        if (wr_stb) begin
            st_d.hold      = wr_data;
            st_d.hold_full = 1'b1;
        end

        if (brk) begin
            st_d.tx = 1'b0;
        end else if (st_d.st == ST_SEND) begin
            st_d.tx = st_d.sh[0];
        end else begin
            st_d.tx = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= ST_IDLE;
            st_q.sh <= '1;
            st_q.tx <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_data  = st_q.hold;
    assign tx_out     = st_q.tx;
    assign hold_empty = ~st_q.hold_full;
    assign all_empty  = ~st_q.hold_full && (st_q.st == ST_IDLE);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [6:0]        line_ctl,
    input  logic [DIV_W-1:0]  divisor,
    output logic              tx_out,
    output logic              hold_empty,
    output logic              all_empty
);

    line_cfg_t          cfg;
    logic               os_tick;
    logic [DATA_W-1:0]  hold_data;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;

    assign cfg = line_cfg_t'(line_ctl);

    sertx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .os_tick (os_tick)
    );

    sertx_frame_fmt u_fmt (
        .data      (hold_data),
        .wlen      (cfg.wlen),
        .two_stop  (cfg.two_stop),
        .par_en    (cfg.par_en),
        .par_even  (cfg.par_even),
        .par_stick (cfg.par_stick),
        .frame     (frame),
        .nbits     (nbits)
    );

    sertx_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .brk        (cfg.brk),
        .frame      (frame),
        .nbits      (nbits),
        .hold_data  (hold_data),
        .tx_out     (tx_out),
        .hold_empty (hold_empty),
        .all_empty  (all_empty)
    );

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic             brk_in,
    input logic [DIV_W-1:0] divisor,
    input logic             tx_out,
    input logic             hold_empty,
    input logic             all_empty
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(brk_in) |-> !tx_out);

    assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(wr_stb) |-> !hold_empty);

    assert_empty_nesting_R9: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> hold_empty);

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && all_empty && !$past(brk_in) |-> tx_out);

    assert_stall_zero_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(divisor) == '0) && !$past(all_empty) |-> !all_empty);

endmodule

bind sertx_top sertx_checker #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .brk_in     (line_ctl[6]),
    .divisor    (divisor),
    .tx_out     (tx_out),
    .hold_empty (hold_empty),
    .all_empty  (all_empty)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [6:0]  line_ctl = 7'h03;
    logic [15:0] divisor = 16'd1;
    logic        tx_out;
    logic        hold_empty;
    logic        all_empty;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    sertx_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .line_ctl   (line_ctl),
        .divisor    (divisor),
        .tx_out     (tx_out),
        .hold_empty (hold_empty),
        .all_empty  (all_empty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected frame built from R2..R5.
    function automatic int exp_frame(input logic [7:0] d, input logic [5:0] lc,
                                     output logic [11:0] f);
        int   wl;
        int   pos;
        logic p;
        wl = 5 + int'(lc[1:0]);
        f = '1;
        f[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < wl; i++) begin
            f[i + 1] = d[i];
            p = p ^ d[i];
        end
        pos = wl + 1;
        if (lc[3]) begin
            if (lc[5]) f[pos] = ~lc[4];
            else       f[pos] = lc[4] ? p : ~p;
            pos++;
        end
        return pos + (lc[2] ? 2 : 1);
    endfunction

    task automatic put(input logic [7:0] d);
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic capture(input int div, input int len, output logic [11:0] bits);
        int waited;
        waited = 0;
        bits = '1;
        while (tx_out !== 1'b0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 4000) chk(1'b0, "R5 start bit timeout", waited, 0);
        repeat (8 * div) @(negedge clk);
        bits[0] = tx_out;
        for (int k = 1; k < len; k++) begin
            repeat (16 * div) @(negedge clk);
            bits[k] = tx_out;
        end
    endtask

    task automatic wait_all_empty(input int limit, output int waited);
        waited = 0;
        while (all_empty !== 1'b1 && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic cmp_frame(input string tag, input logic [11:0] got,
                             input logic [11:0] exp, input int len);
        logic [11:0] mask;
        mask = 12'((13'h1 << len) - 1);
        chk((got & mask) == (exp & mask), tag, int'(got & mask), int'(exp & mask));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] got;
        logic [11:0] exp;
        int          len;
        int          w;
        int          dv;
        logic [7:0]  d;
        logic [5:0]  lc;
        void'($urandom(32'h5EED_7A11));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_out == 1'b1, "R1 tx idle", int'(tx_out), 1);
        chk(hold_empty == 1'b1, "R1 hold_empty", int'(hold_empty), 1);
        chk(all_empty == 1'b1, "R1 all_empty", int'(all_empty), 1);

        // R8 / R9 flag sequence
        divisor  = 16'd2;
        line_ctl = 7'b000_0011;
        put(8'hA5);
        chk(hold_empty == 1'b0, "R8 hold full after write", int'(hold_empty), 0);
        chk(all_empty == 1'b0, "R9 busy after write", int'(all_empty), 0);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R8 hold freed on take", int'(hold_empty), 1);
        chk(all_empty == 1'b0, "R9 busy while shifting", int'(all_empty), 0);
        len = exp_frame(8'hA5, 6'b000011, exp);
        capture(2, len, got);
        cmp_frame("R5 frame 8N1", got, exp, len);
        wait_all_empty(200, w);
        chk(all_empty == 1'b1, "R9 empty after stop", w, 0);

        // R6 bit time: 0x00, 8N1, divisor 5 -> 9 low bits
        divisor = 16'd5;
        put(8'h00);
        w = 0;
        while (tx_out !== 1'b0 && w < 100) begin @(negedge clk); w++; end
        w = 0;
        while (tx_out === 1'b0 && w < 2000) begin @(negedge clk); w++; end
        chk(w >= 9 * 80 - 4 && w <= 9 * 80, "R6 low run length", w, 9 * 80);
        wait_all_empty(400, w);

        // R4 directed: odd parity, 7 bits, two stops; fixed parity with even select 0
        divisor  = 16'd1;
        line_ctl = 7'b000_1110;
        len = exp_frame(8'h13, 6'b001110, exp);
        put(8'h13);
        capture(1, len, got);
        cmp_frame("R4 odd parity 7O2", got, exp, len);
        wait_all_empty(100, w);
        line_ctl = 7'b010_1000;
        len = exp_frame(8'h0F, 6'b101000, exp);
        put(8'h0F);
        capture(1, len, got);
        cmp_frame("R4 fixed parity 5 bits", got, exp, len);
        chk(got[6] == 1'b1, "R4 fixed parity bit", int'(got[6]), 1);
        wait_all_empty(100, w);

        // R7 break while idle
        line_ctl = 7'b100_0011;
        repeat (2) @(negedge clk);
        chk(tx_out == 1'b0, "R7 break drives low", int'(tx_out), 0);
        chk(all_empty == 1'b1, "R7 flags kept", int'(all_empty), 1);
        line_ctl = 7'b000_0011;
        repeat (2) @(negedge clk);
        chk(tx_out == 1'b1, "R7 break released", int'(tx_out), 1);

        // R6 divisor zero stalls
        divisor = 16'd0;
        put(8'h55);
        repeat (300) @(negedge clk);
        chk(tx_out == 1'b0, "R6 stalled in start bit", int'(tx_out), 0);
        chk(all_empty == 1'b0, "R6 stalled busy", int'(all_empty), 0);
        divisor = 16'd2;
        wait_all_empty(1000, w);
        chk(all_empty == 1'b1 && tx_out == 1'b1, "R6 resumes", int'(all_empty), 1);

        // R10 overwrite while full
        divisor = 16'd1;
        line_ctl = 7'b000_0011;
        put(8'h3C);
        fork
            capture(1, 10, got);
            begin
                repeat (40) @(negedge clk);
                put(8'h81);
                put(8'hE7);
                chk(hold_empty == 1'b0, "R10 hold full pending", int'(hold_empty), 0);
            end
        join
        len = exp_frame(8'h3C, 6'b000011, exp);
        cmp_frame("R10 first frame", got, exp, len);
        capture(1, 10, got);
        len = exp_frame(8'hE7, 6'b000011, exp);
        cmp_frame("R10 newest byte sent", got, exp, len);
        wait_all_empty(100, w);
        chk(all_empty == 1'b1, "R9 empty after pair", int'(all_empty), 1);

        // Random frames, format disturbed mid-frame (R2 R3 R4 R11)
        for (int it = 0; it < 30; it++) begin
            d  = 8'($urandom);
            lc = 6'($urandom);
            dv = 1 + int'($urandom % 3);
            divisor  = 16'(dv);
            line_ctl = {1'b0, lc};
            len = exp_frame(d, lc, exp);
            put(d);
            repeat (2) @(negedge clk);
            line_ctl = {1'b0, 6'($urandom)};
            capture(dv, len, got);
            cmp_frame("R2 R3 R4 R11 random frame", got, exp, len);
            wait_all_empty(64 * dv, w);
            chk(all_empty == 1'b1 && tx_out == 1'b1, "R9 R5 idle after frame",
                int'(all_empty), 1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule